// File: doc/BRIEF.md
# Multi-Core Interrupt Vector Router

This block collects 256 edge-signalled device interrupts for one node and turns them into per-core CPU interrupt lines. A rising edge on any input marks that vector pending. Each pending vector passes an enable gate and a route byte. The route byte names a local node and a set of target cores. Each group of 32 vectors then picks the CPU interrupt line it drives through a one-hot map byte. The output is a bank of four cores by eight lines, registered.

Software configures the router and services interrupts through a simple request/response register port. The port is 64 bits wide and naturally aligned, with per-byte write strobes. A 32-bit access uses four of the strobes. Storage banks are byte-addressed and little-endian. The pending bank is read in 64-bit words and cleared by writing ones to the bits to clear. A handler can therefore write back exactly what it read without losing an edge that arrived in between. Two banks are plain storage that software may initialise: a node mask and a per-vector auxiliary flag.

Top module: `vec_router`

## Requirements
- R1: After reset every bank reads zero, `rsp_valid` is low and `cpu_irq` is all zero.
- R2: A rising edge on `irq_in[v]` sets pending bit v, seen at bit v%64 of the word at 0x1800+8*(v/64). An input held high does not set the bit again after it is cleared.
- R3: A write to a pending word clears each bit whose data bit is one in a byte lane with its strobe set. Bits written as zero, and bits in unstrobed lanes, are kept.
- R4: When a rising edge and a clear hit the same pending bit in the same cycle, the bit stays set.
- R5: Enable bit v sits in the byte at 0x1600+v/8, bit v%8. A pending vector whose enable bit is zero drives no line and stays pending. Setting the bit again delivers it.
- R6: Route byte v sits at 0x1C00+v. Bits 3:0 are a core bitmap, with bit c selecting core c. Bits 7:4 are a node number. The vector is delivered only when that number equals `node_id`, and then to every core whose bit is set. Rewriting the byte re-steers a vector that is already pending.
- R7: Map byte g sits at 0x14C0+g and serves vectors 32g to 32g+31. Bit l set makes the group drive line l. Core c line l is `cpu_irq[8c+l]`.
- R8: In the enable, route, map, node-mask and auxiliary banks, only byte lanes with their strobe set are written.
- R9: The node mask at 0x14A0..0x14BF and the auxiliary flags at 0x1680..0x169F read back as written and have no effect on `cpu_irq`.
- R10: Reads of unmapped addresses return zero, and writes to them change nothing.
- R11: A read request gives `rsp_valid` high with its data one cycle later. `cpu_irq` follows a change of pending or configuration state one cycle after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_id | input | 4 | Number of the local node, compared against route node fields |
| irq_in | input | 256 | Edge-signalled device interrupt inputs |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address, 8-byte aligned |
| req_wdata | input | 64 | Write data |
| req_wstrb | input | 8 | Byte write strobes |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| cpu_irq | output | 32 | Per-core interrupt lines, index 8*core+line |

## Verification
The bench targets a set and a clear that land in the same cycle. A design that lets the clear win would silently drop an interrupt that arrived during service. It also targets a write-back that names only some of the pending bits, or that leaves a lane unstrobed. A design that clears the whole word would lose the other sources. Each vector is raised in turn with a different core, and the line map of one group is swept over all eight lines. A wrong byte-lane, group or core index would light the wrong output or none. The bench also re-routes a vector while it is pending: to a foreign node, to all cores and to a single core. It writes the storage-only banks, unmapped addresses and partial strobes. A stale route, a bad node compare or a decode overlap would show as wrong lines or wrong read-back.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
  localparam int ADDR_W = 16;
  localparam int BUS_W  = 64;
  localparam int LANES  = BUS_W / 8;

  // Bank base offsets (byte addresses)
  localparam int NODE_MASK_BASE = 'h14A0;
  localparam int LINE_MAP_BASE  = 'h14C0;
  localparam int ENABLE_BASE    = 'h1600;
  localparam int AUX_FLAG_BASE  = 'h1680;
  localparam int PEND_BASE      = 'h1800;
  localparam int ROUTE_BASE     = 'h1C00;

  // Route byte layout: core bitmap low, node number high
  localparam int ROUTE_CORE_LSB = 0;
  localparam int ROUTE_NODE_LSB = 4;
  localparam int NODE_W         = 4;
  localparam int GROUP_SIZE     = 32;
endpackage

// File: rtl/vrt_regbank.sv
module vrt_regbank
  import vrt_pkg::*;
#(
  parameter int BASE   = 0,
  parameter int NBYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BUS_W-1:0]        wdata,
  input  logic [LANES-1:0]        wstrb,
  output logic [NBYTES*8-1:0]     store
);
  localparam int NWORDS = NBYTES / LANES;

  logic [NBYTES*8-1:0] store_q, store_d;
  int                  widx;
  logic                hit;

  always_comb begin
    widx = int'(addr >> 3) - BASE / LANES;
    hit  = (widx >= 0) && (widx < NWORDS);
  end

  always_comb begin
    store_d = store_q;
    if (wr_en && hit) begin
      for (int b = 0; b < LANES; b++) begin
        if (wstrb[b]) store_d[widx*BUS_W + b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             store_q <= '0;
    else if (wr_en && hit)  store_q <= store_d;
  end

  assign store = store_q;
endmodule

// File: rtl/vrt_pendbank.sv
module vrt_pendbank
  import vrt_pkg::*;
#(
  parameter int BASE    = 0,
  parameter int NUM_VEC = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_VEC-1:0]  irq_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  input  logic [LANES-1:0]    wstrb,
  output logic [NUM_VEC-1:0]  pending
);
  localparam int NWORDS = NUM_VEC / BUS_W;

  logic [NUM_VEC-1:0] irq_q, rise, clr, pend_q, pend_d;
  int                 widx;
  logic               hit;

  always_comb begin
    widx = int'(addr >> 3) - BASE / LANES;
    hit  = (widx >= 0) && (widx < NWORDS);
  end

  assign rise = irq_in & ~irq_q;

  always_comb begin
    clr = '0;
    if (wr_en && hit) begin
      for (int b = 0; b < LANES; b++) begin
        if (wstrb[b]) clr[widx*BUS_W + b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
  end

  // a new edge outranks a clear of the same bit
  assign pend_d = (pend_q & ~clr) | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/vrt_rdsel.sv
module vrt_rdsel
  import vrt_pkg::*;
#(
  parameter int BASE   = 0,
  parameter int NBYTES = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NBYTES*8-1:0] bits,
  output logic [BUS_W-1:0]    rword
);
  localparam int NWORDS = NBYTES / LANES;
  int widx;

  always_comb begin
    widx  = int'(addr >> 3) - BASE / LANES;
    rword = '0;
    if ((widx >= 0) && (widx < NWORDS)) rword = bits[widx*BUS_W +: BUS_W];
  end
endmodule

// File: rtl/vrt_dispatch.sv
module vrt_dispatch
  import vrt_pkg::*;
#(
  parameter int NUM_VEC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_LINE = 8
) (
  input  logic [NUM_VEC-1:0]              pending,
  input  logic [NUM_VEC-1:0]              enable,
  input  logic [NUM_VEC*8-1:0]            route,
  input  logic [(NUM_VEC/GROUP_SIZE)*8-1:0] line_map,
  input  logic [NODE_W-1:0]               node_id,
  output logic [NUM_CORE*NUM_LINE-1:0]    lines
);
  localparam int NUM_GRP = NUM_VEC / GROUP_SIZE;

  logic [NUM_VEC-1:0]                 live;
  logic [NUM_CORE-1:0][NUM_VEC-1:0]   core_sel;
  logic [NUM_GRP-1:0][NUM_CORE-1:0]   grp_hit;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign live[v] = pending[v] & enable[v] &
                     (route[v*8 + ROUTE_NODE_LSB +: NODE_W] == node_id);
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign core_sel[c][v] = route[v*8 + ROUTE_CORE_LSB + c];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign grp_hit[g][c] = |(live[g*GROUP_SIZE +: GROUP_SIZE] &
                               core_sel[c][g*GROUP_SIZE +: GROUP_SIZE]);
    end
  end

  always_comb begin
    lines = '0;
    for (int c = 0; c < NUM_CORE; c++) begin
      for (int l = 0; l < NUM_LINE; l++) begin
        for (int g = 0; g < NUM_GRP; g++) begin
          lines[c*NUM_LINE + l] = lines[c*NUM_LINE + l] |
                                  (grp_hit[g][c] & line_map[g*8 + l]);
        end
      end
    end
  end
endmodule

// File: rtl/vec_router.sv
module vec_router
  import vrt_pkg::*;
#(
  parameter int NUM_VEC  = 256,
  parameter int NUM_CORE = 4,
  parameter int NUM_LINE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [3:0]                    node_id,
  input  logic [NUM_VEC-1:0]            irq_in,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [15:0]                   req_addr,
  input  logic [63:0]                   req_wdata,
  input  logic [7:0]                    req_wstrb,
  output logic                          rsp_valid,
  output logic [63:0]                   rsp_rdata,
  output logic [NUM_CORE*NUM_LINE-1:0]  cpu_irq
);
  localparam int NUM_GRP    = NUM_VEC / GROUP_SIZE;
  localparam int BIT_BYTES  = NUM_VEC / 8;
  localparam int MAP_BYTES  = NUM_GRP;
  localparam int OUT_W      = NUM_CORE * NUM_LINE;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic wr_en, rd_en;
  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  logic [BIT_BYTES*8-1:0] node_mask_bits, en_bits, aux_bits;
  logic [MAP_BYTES*8-1:0] map_bits;
  logic [NUM_VEC*8-1:0]   route_bits;
  logic [NUM_VEC-1:0]     pend_bits;

  vrt_regbank #(.BASE(NODE_MASK_BASE), .NBYTES(BIT_BYTES)) u_node_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .wstrb(req_wstrb), .store(node_mask_bits));
  vrt_regbank #(.BASE(LINE_MAP_BASE), .NBYTES(MAP_BYTES)) u_line_map (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .wstrb(req_wstrb), .store(map_bits));
  vrt_regbank #(.BASE(ENABLE_BASE), .NBYTES(BIT_BYTES)) u_enable (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .wstrb(req_wstrb), .store(en_bits));
  vrt_regbank #(.BASE(AUX_FLAG_BASE), .NBYTES(BIT_BYTES)) u_aux (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .wstrb(req_wstrb), .store(aux_bits));
  vrt_regbank #(.BASE(ROUTE_BASE), .NBYTES(NUM_VEC)) u_route (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(req_addr),
    .wdata(req_wdata), .wstrb(req_wstrb), .store(route_bits));

  vrt_pendbank #(.BASE(PEND_BASE), .NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(req_addr), .wdata(req_wdata), .wstrb(req_wstrb), .pending(pend_bits));

  // read path: each bank returns zero outside its own window
  logic [63:0] rw_node, rw_map, rw_en, rw_aux, rw_route, rw_pend, rdata_d;

  vrt_rdsel #(.BASE(NODE_MASK_BASE), .NBYTES(BIT_BYTES)) u_rd_node (
    .addr(req_addr), .bits(node_mask_bits), .rword(rw_node));
  vrt_rdsel #(.BASE(LINE_MAP_BASE), .NBYTES(MAP_BYTES)) u_rd_map (
    .addr(req_addr), .bits(map_bits), .rword(rw_map));
  vrt_rdsel #(.BASE(ENABLE_BASE), .NBYTES(BIT_BYTES)) u_rd_en (
    .addr(req_addr), .bits(en_bits), .rword(rw_en));
  vrt_rdsel #(.BASE(AUX_FLAG_BASE), .NBYTES(BIT_BYTES)) u_rd_aux (
    .addr(req_addr), .bits(aux_bits), .rword(rw_aux));
  vrt_rdsel #(.BASE(ROUTE_BASE), .NBYTES(NUM_VEC)) u_rd_route (
    .addr(req_addr), .bits(route_bits), .rword(rw_route));
  vrt_rdsel #(.BASE(PEND_BASE), .NBYTES(BIT_BYTES)) u_rd_pend (
    .addr(req_addr), .bits(pend_bits), .rword(rw_pend));

  assign rdata_d = rw_node | rw_map | rw_en | rw_aux | rw_route | rw_pend;

  logic        rsp_valid_q;
  logic [63:0] rsp_rdata_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_valid_q <= 1'b0;
    else             rsp_valid_q <= rd_en;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_rdata_q <= '0;
    else if (rd_en)  rsp_rdata_q <= rdata_d;
  end
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // delivery
  logic [OUT_W-1:0] lines_d, lines_q;
  vrt_dispatch #(.NUM_VEC(NUM_VEC), .NUM_CORE(NUM_CORE), .NUM_LINE(NUM_LINE)) u_disp (
    .pending(pend_bits), .enable(en_bits), .route(route_bits),
    .line_map(map_bits), .node_id(node_id), .lines(lines_d));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) lines_q <= '0;
    else             lines_q <= lines_d;
  end
  assign cpu_irq = lines_q;
endmodule

module vec_router_chk #(
  parameter int NUM_VEC = 256,
  parameter int OUT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_VEC-1:0] irq_in,
  input logic [NUM_VEC-1:0] pending,
  input logic [NUM_VEC-1:0] enable,
  input logic               req_valid,
  input logic               req_write,
  input logic               rsp_valid,
  input logic [OUT_W-1:0]   cpu_irq
);
  logic [NUM_VEC-1:0] irq_seen, rise_c;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_seen <= '0;
    else        irq_seen <= irq_in;
  end
  assign rise_c = irq_in & ~irq_seen;

  // R2 / R4: every edge lands in pending, whatever clear is in flight
  a_r4_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_c != '0) |=> ((pending & $past(rise_c)) == $past(rise_c)));

  // R2: no pending bit appears without an edge
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(rise_c)) == '0));

  // R5: nothing pending and enabled means all lines low next cycle
  a_r5_gated_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & enable) == '0) |=> (cpu_irq == '0));

  // R11: read response one cycle after a read request, and only then
  a_r11_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r11_rsp_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind vec_router vec_router_chk #(.NUM_VEC(NUM_VEC), .OUT_W(NUM_CORE*NUM_LINE)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .pending(pend_bits),
  .enable(en_bits), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .cpu_irq(cpu_irq));

// File: tb/vec_router_tb_top.sv
module vec_router_tb_top;
  localparam int NV   = 256;
  localparam int OUTW = 32;
  localparam logic [3:0] MY_NODE = 4'h3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3:0]      node_id;
  logic [NV-1:0]   irq_in;
  logic            req_valid, req_write;
  logic [15:0]     req_addr;
  logic [63:0]     req_wdata;
  logic [7:0]      req_wstrb;
  logic            rsp_valid;
  logic [63:0]     rsp_rdata;
  logic [OUTW-1:0] cpu_irq;

  always #2 clk = ~clk;

  vec_router dut_i (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .irq_in(irq_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model
  logic [NV-1:0] pend_m, en_m;
  logic [7:0]    rt_m [NV];
  logic [7:0]    mp_m [8];

  function automatic logic [OUTW-1:0] exp_lines();
    logic [OUTW-1:0] e = '0;
    for (int v = 0; v < NV; v++)
      if (pend_m[v] && en_m[v] && rt_m[v][7:4] == MY_NODE)
        for (int c = 0; c < 4; c++)
          if (rt_m[v][c])
            for (int l = 0; l < 8; l++)
              if (mp_m[v/32][l]) e[c*8+l] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr64(input logic [15:0] a, input logic [63:0] d, input logic [7:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_byte(input int a, input logic [7:0] b);
    wr64(16'(a & ~7), 64'(b) << (8 * (a & 7)), 8'(1 << (a & 7)));
  endtask

  task automatic rd64(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse(input int v);
    @(negedge clk); irq_in[v] = 1'b1; pend_m[v] = 1'b1;
    @(negedge clk); irq_in[v] = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_vec(input int v);
    logic [63:0] m = 64'd1 << (v % 64);
    wr64(16'(16'h1800 + 8*(v/64)), m, 8'hFF);
    pend_m[v] = 1'b0;
  endtask

  task automatic chk_lines(input string tag);
    chk(tag, 64'(cpu_irq), 64'(exp_lines()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    rst_n = 1'b0; node_id = MY_NODE; irq_in = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_wstrb = '0;
    pend_m = '0; en_m = '0;
    for (int v = 0; v < NV; v++) rt_m[v] = '0;
    for (int g = 0; g < 8; g++) mp_m[g] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cpu_irq", 64'(cpu_irq), 64'd0);
    chk("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
    rd64(16'h1800, rd); chk("R1 pending", rd, 64'd0);
    rd64(16'h1600, rd); chk("R1 enable", rd, 64'd0);
    rd64(16'h1C00, rd); chk("R1 route", rd, 64'd0);
    rd64(16'h14C0, rd); chk("R1 line map", rd, 64'd0);

    // R10 unmapped
    wr64(16'h1700, '1, 8'hFF);
    rd64(16'h1700, rd); chk("R10 unmapped read", rd, 64'd0);
    rd64(16'h0008, rd); chk("R10 low address read", rd, 64'd0);
    rd64(16'h1620, rd); chk("R10 past enable bank", rd, 64'd0);

    // R8 partial strobes on route word
    wr64(16'h1C00, 64'h8877665544332211, 8'h05);
    rd64(16'h1C00, rd); chk("R8 route strobes", rd, 64'h0000000000330011);
    wr64(16'h1C00, 64'd0, 8'hFF);

    // enable everything, program line maps
    for (int w = 0; w < 4; w++) wr64(16'(16'h1600 + 8*w), '1, 8'hFF);
    en_m = '1;
    rd64(16'h1618, rd); chk("R5 enable readback", rd, '1);
    for (int g = 0; g < 8; g++) mp_m[g] = 8'(1 << ((g*3) % 8));
    wr64(16'h14C0, {mp_m[7], mp_m[6], mp_m[5], mp_m[4], mp_m[3], mp_m[2], mp_m[1], mp_m[0]}, 8'hFF);
    rd64(16'h14C0, rd);
    chk("R7 map readback", rd, {mp_m[7], mp_m[6], mp_m[5], mp_m[4], mp_m[3], mp_m[2], mp_m[1], mp_m[0]});

    // R9 storage-only banks
    wr64(16'h14A8, 64'hA5A5_0F0F_1234_5678, 8'hFF);
    rd64(16'h14A8, rd); chk("R9 node mask", rd, 64'hA5A5_0F0F_1234_5678);
    wr64(16'h1688, 64'hFFFF_0000_FFFF_0000, 8'hF0);
    rd64(16'h1688, rd); chk("R9 aux flags strobed", rd, 64'hFFFF_0000_0000_0000);
    chk("R9 no line effect", 64'(cpu_irq), 64'd0);

    // R7 sweep all lines of group 0
    rt_m[0] = {MY_NODE, 4'b0001}; wr_byte(16'h1C00, rt_m[0]);
    pulse(0);
    for (int l = 0; l < 8; l++) begin
      mp_m[0] = 8'(1 << l); wr_byte(16'h14C0, mp_m[0]);
      chk_lines("R7 group line select");
    end
    mp_m[0] = 8'h01; wr_byte(16'h14C0, mp_m[0]);
    clear_vec(0);
    rt_m[0] = '0; wr_byte(16'h1C00, 8'h00);

    // R2 / R3 / R6 sweep of every vector
    for (int v = 0; v < NV; v++) begin
      rt_m[v] = {MY_NODE, 4'(1 << (v % 4))};
      wr_byte(16'h1C00 + v, rt_m[v]);
      pulse(v);
      rd64(16'(16'h1800 + 8*(v/64)), rd);
      chk("R2 pending set", rd, pend_m[64*(v/64) +: 64]);
      chk_lines("R6 core routing");
      wr64(16'(16'h1800 + 8*(v/64)), rd, 8'hFF);
      pend_m[64*(v/64) +: 64] = pend_m[64*(v/64) +: 64] & ~rd;
      rd64(16'(16'h1800 + 8*(v/64)), rd);
      chk("R3 write-back clears", rd, 64'd0);
      chk_lines("R3 lines drop");
    end

    // R5 enable gating on vector 70
    pulse(70);
    chk_lines("R5 enabled delivery");
    en_m[70] = 1'b0; wr_byte(16'h1600 + 70/8, en_m[64 +: 8]);
    chk_lines("R5 masked");
    chk("R5 masked no line", 64'(cpu_irq), 64'd0);
    rd64(16'h1808, rd); chk("R5 still pending", rd, pend_m[64 +: 64]);
    en_m[70] = 1'b1; wr_byte(16'h1600 + 70/8, en_m[64 +: 8]);
    chk_lines("R5 unmasked");

    // R6 node filter and re-steering while pending
    rt_m[70] = {4'h5, 4'b0001}; wr_byte(16'h1C00 + 70, rt_m[70]);
    chk("R6 foreign node", 64'(cpu_irq), 64'd0);
    rt_m[70] = {MY_NODE, 4'b1111}; wr_byte(16'h1C00 + 70, rt_m[70]);
    chk_lines("R6 all cores");
    rt_m[70] = {MY_NODE, 4'b0100}; wr_byte(16'h1C00 + 70, rt_m[70]);
    chk_lines("R6 core two only");
    clear_vec(70);
    chk_lines("R6 cleared");

    // R3 partial clear and unstrobed lane
    pulse(130); pulse(131);
    wr64(16'h1810, 64'd1 << 3, 8'h00);
    rd64(16'h1810, rd); chk("R3 unstrobed lane keeps", rd, pend_m[128 +: 64]);
    wr64(16'h1810, 64'd1 << 2, 8'hFF); pend_m[130] = 1'b0;
    rd64(16'h1810, rd); chk("R3 only named bit cleared", rd, pend_m[128 +: 64]);
    chk_lines("R3 remaining vector lines");
    clear_vec(131);

    // R4 edge and clear in the same cycle
    pulse(200);
    @(negedge clk);
    irq_in[200] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1818;
    req_wdata = 64'd1 << (200 % 64); req_wstrb = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    rd64(16'h1818, rd); chk("R4 set wins", rd, pend_m[192 +: 64]);
    chk_lines("R4 lines stay");
    // R2 held level does not re-set
    clear_vec(200);
    repeat (2) @(negedge clk);
    rd64(16'h1818, rd); chk("R2 held level no reset", rd, 64'd0);
    irq_in[200] = 1'b0;
    chk("R1 idle lines at end", 64'(cpu_irq), 64'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule